// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Controller

This block gives a processor word-wide control over a bank of general-purpose pins through a small synchronous register port (address, write strobe, write data, combinational read data). Every pin has an output level, an output enable and an input that is resynchronised before software can read it. The register width equals the pin count and may be 8, 16, 32 or 64.

Three build-time choices shape the register file. The write style is one of three: a plain data register that loads the whole output latch, a set/clear pair that changes only the bits written as 1, or a single full-width set register that holds the output value. The direction scheme is one of three: none (every pin driven, nothing to configure), a direction register where 1 means output, or one where 1 means input. The pin-to-bit numbering may be reversed. The register offsets are fixed: 0 for pin data, 1 for set, 2 for clear, 3 for direction. All other offsets read as zero.

Top module: `mmio_gpio_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the output latch is all zeros. In output-high direction mode the direction register is zero and `pin_oe` is zero. In input-high mode it is all ones and `pin_oe` is zero.
- R2: A read at offset 0 returns the pin levels `SYNC_STAGES` rising edges (default 2) after they are applied. After one edge the old level is still returned.
- R3: In plain write style, a write to offset 0 loads every bit of the output latch. 1 drives the pin high and 0 drives it low.
- R4: In set/clear style, a write to offset 1 sets each latch bit whose written bit is 1. Bits written as 0 keep their value.
- R5: In set/clear style, a write to offset 2 clears each latch bit whose written bit is 1 and leaves the others unchanged. Writes to offset 0 do not change the latch in set/clear or set-only style.
- R6: In set-only style, a write to offset 1 loads the whole latch. A read at offset 1 returns the latch when `SET_READABLE` is 1 and zero when it is 0.
- R7: In output-high direction mode, a direction bit of 1 sets that pin's `pin_oe` high. Offset 3 reads back the direction register.
- R8: In input-high direction mode, a direction bit of 1 makes that pin an input (`pin_oe` low) and 0 makes it an output. Offset 3 reads back the register.
- R9: With no direction register, `pin_oe` is all ones. Writes to offset 3 have no effect and offset 3 reads zero.
- R10: With `REVERSED` set, pin i maps to register bit W-1-i in every register, including data read, latch and direction. Otherwise pin i maps to bit i.
- R11: Offsets 4 and above read zero and writes there change nothing. Offsets of registers absent from the chosen style also read zero: 1 and 2 in plain style, 1 in set/clear style, 2 in set-only style.
- R12: A write takes effect on the rising edge that accepts it. A read of the same register in that cycle returns the value from before the write. Without a write, `pin_out` and `pin_oe` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for `bus_addr`, combinational |
| pin_in | input | W | Asynchronous pin levels |
| pin_out | output | W | Output latch per pin |
| pin_oe | output | W | Output enable per pin, 1 = driven |

## Verification
The case that matters is a register write and a read of that same register landing in one cycle. The bench provokes it on the set register of a readable set-only instance. Read data is sampled just after the strobe rises, where it must still show the previous latch value. It is sampled again one cycle later, where the new value must appear on both the read path and the pins. The second case is a pin change overlapping continuous reads of offset 0. The bench samples after one edge and after two, so a short or long synchroniser is caught.

// File: rtl/gpio_ctl_pkg.sv
package gpio_ctl_pkg;

    typedef enum logic [1:0] {
        WR_PLAIN   = 2'd0,
        WR_SETCLR  = 2'd1,
        WR_SETONLY = 2'd2
    } wr_style_e;

    typedef enum logic [1:0] {
        DIR_NONE   = 2'd0,
        DIR_OUT_HI = 2'd1,
        DIR_IN_HI  = 2'd2
    } dir_style_e;

    localparam int OFS_DATA = 0;
    localparam int OFS_SET  = 1;
    localparam int OFS_CLR  = 2;
    localparam int OFS_DIR  = 3;

endpackage

// File: rtl/gpio_bit_order.sv
module gpio_bit_order #(
    parameter int W   = 8,
    parameter bit REV = 1'b0
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    generate
        if (REV) begin : g_rev
            for (genvar i = 0; i < W; i++) begin : g_bit
                assign dout[i] = din[W-1-i];
            end
        end else begin : g_fwd
            assign dout = din;
        end
    endgenerate

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= din;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
    import gpio_ctl_pkg::*;
#(
    parameter int        W        = 8,
    parameter wr_style_e WR_STYLE = WR_SETCLR
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_data,
    input  logic         wr_set,
    input  logic         wr_clr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] latch_q
);

    logic unused_sink;
    assign unused_sink = ^{wr_data, wr_set, wr_clr};

    generate
        if (WR_STYLE == WR_PLAIN) begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       latch_q <= '0;
                else if (wr_data) latch_q <= wdata;
            end
        end else if (WR_STYLE == WR_SETCLR) begin : g_setclr
            logic [W-1:0] set_m, clr_m;
            assign set_m = wr_set ? wdata : '0;
            assign clr_m = wr_clr ? wdata : '0;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                latch_q <= '0;
                else if (wr_set || wr_clr) latch_q <= (latch_q | set_m) & ~clr_m;
            end
        end else begin : g_setonly
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      latch_q <= '0;
                else if (wr_set) latch_q <= wdata;
            end
        end
    endgenerate

endmodule

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg
    import gpio_ctl_pkg::*;
#(
    parameter int         W         = 8,
    parameter dir_style_e DIR_STYLE = DIR_OUT_HI
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_dir,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dir_rd,
    output logic [W-1:0] oe_reg
);

    logic unused_sink;
    assign unused_sink = ^{clk, rst_n, wr_dir, wdata};

    generate
        if (DIR_STYLE == DIR_NONE) begin : g_none
            assign dir_rd = '0;
            assign oe_reg = '1;
        end else begin : g_reg
            localparam logic [W-1:0] RST_VAL = (DIR_STYLE == DIR_IN_HI) ? '1 : '0;
            logic [W-1:0] dir_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      dir_q <= RST_VAL;
                else if (wr_dir) dir_q <= wdata;
            end
            assign dir_rd = dir_q;
            if (DIR_STYLE == DIR_IN_HI) begin : g_inv
                assign oe_reg = ~dir_q;
            end else begin : g_pos
                assign oe_reg = dir_q;
            end
        end
    endgenerate

endmodule

// File: rtl/mmio_gpio_ctrl.sv
module mmio_gpio_ctrl
    import gpio_ctl_pkg::*;
#(
    parameter int         W            = 8,
    parameter int         ADDR_W       = 3,
    parameter int         SYNC_STAGES  = 2,
    parameter wr_style_e  WR_STYLE     = WR_SETCLR,
    parameter dir_style_e DIR_STYLE    = DIR_OUT_HI,
    parameter bit         REVERSED     = 1'b0,
    parameter bit         SET_READABLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe
);

    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
    localparam bit SET_VISIBLE = (WR_STYLE == WR_SETONLY) && SET_READABLE;

    logic         wr_data, wr_set, wr_clr, wr_dir;
    logic [W-1:0] pin_sync, in_reg, latch_q, dir_rd, oe_reg;

    assign wr_data = bus_we && (bus_addr == A_DATA);
    assign wr_set  = bus_we && (bus_addr == A_SET);
    assign wr_clr  = bus_we && (bus_addr == A_CLR);
    assign wr_dir  = bus_we && (bus_addr == A_DIR);

    gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(pin_sync)
    );

    gpio_bit_order #(.W(W), .REV(REVERSED)) u_ord_in (
        .din(pin_sync), .dout(in_reg)
    );

    gpio_out_latch #(.W(W), .WR_STYLE(WR_STYLE)) u_latch (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_set(wr_set),
        .wr_clr(wr_clr), .wdata(bus_wdata), .latch_q(latch_q)
    );

    gpio_bit_order #(.W(W), .REV(REVERSED)) u_ord_out (
        .din(latch_q), .dout(pin_out)
    );

    gpio_dir_reg #(.W(W), .DIR_STYLE(DIR_STYLE)) u_dir (
        .clk(clk), .rst_n(rst_n), .wr_dir(wr_dir), .wdata(bus_wdata),
        .dir_rd(dir_rd), .oe_reg(oe_reg)
    );

    gpio_bit_order #(.W(W), .REV(REVERSED)) u_ord_oe (
        .din(oe_reg), .dout(pin_oe)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_DATA) begin
            bus_rdata = in_reg;
        end else if (bus_addr == A_SET) begin
            if (SET_VISIBLE) bus_rdata = latch_q;
        end else if (bus_addr == A_DIR) begin
            bus_rdata = dir_rd;
        end
    end

endmodule

// File: rtl/mmio_gpio_ctrl_chk.sv
module mmio_gpio_ctrl_chk
    import gpio_ctl_pkg::*;
#(
    parameter int         W            = 8,
    parameter int         ADDR_W       = 3,
    parameter wr_style_e  WR_STYLE     = WR_SETCLR,
    parameter dir_style_e DIR_STYLE    = DIR_OUT_HI,
    parameter bit         REVERSED     = 1'b0,
    parameter bit         SET_READABLE = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      bus_rdata,
    input logic [W-1:0]      pin_out,
    input logic [W-1:0]      pin_oe
);

    function automatic logic [W-1:0] to_reg(input logic [W-1:0] v);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = REVERSED ? v[W-1-i] : v[i];
        return r;
    endfunction

    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);

    AST_PLAIN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (WR_STYLE == WR_PLAIN && bus_we && bus_addr == A_DATA) |=> to_reg(pin_out) == $past(bus_wdata)); // R3

    AST_SET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
        (WR_STYLE == WR_SETCLR && bus_we && bus_addr == A_SET) |=> to_reg(pin_out) == ($past(to_reg(pin_out)) | $past(bus_wdata))); // R4

    AST_CLR_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (WR_STYLE == WR_SETCLR && bus_we && bus_addr == A_CLR) |=> to_reg(pin_out) == ($past(to_reg(pin_out)) & ~$past(bus_wdata))); // R5

    AST_SETONLY_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (WR_STYLE == WR_SETONLY && bus_we && bus_addr == A_SET) |=> to_reg(pin_out) == $past(bus_wdata)); // R6

    AST_SET_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (WR_STYLE == WR_SETONLY && SET_READABLE && bus_addr == A_SET) |-> bus_rdata == to_reg(pin_out)); // R6

    AST_DIROUT_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (DIR_STYLE == DIR_OUT_HI && bus_addr == A_DIR) |-> bus_rdata == to_reg(pin_oe)); // R7

    AST_DIRIN_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (DIR_STYLE == DIR_IN_HI && bus_addr == A_DIR) |-> bus_rdata == ~to_reg(pin_oe)); // R8

    AST_NODIR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (DIR_STYLE == DIR_NONE && bus_addr == A_DIR) |-> (bus_rdata == '0 && pin_oe == '1)); // R9

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > A_DIR) |-> bus_rdata == '0); // R11

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we) |=> ($stable(pin_out) && $stable(pin_oe))); // R12

    AST_DATA_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (WR_STYLE != WR_PLAIN && bus_we && bus_addr == A_DATA) |=> $stable(pin_out)); // R5

endmodule

bind mmio_gpio_ctrl mmio_gpio_ctrl_chk #(
    .W(W), .ADDR_W(ADDR_W), .WR_STYLE(WR_STYLE), .DIR_STYLE(DIR_STYLE),
    .REVERSED(REVERSED), .SET_READABLE(SET_READABLE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/sim_mmio_gpio_ctrl.sv
`timescale 1ns/1ps
module sim_mmio_gpio_ctrl;
    import gpio_ctl_pkg::*;

    localparam int W  = 8;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          we = 1'b0;
    logic [W-1:0]  wdata = '0;
    logic [W-1:0]  pins = '0;
    logic [W-1:0]  rd0, rd1, rd2, rd3, out0, out1, out2, out3, oe0, oe1, oe2, oe3;

    always #2.5 clk = ~clk;

    // u0: set/clear, output-high direction, forward order
    mmio_gpio_ctrl #(.W(W), .ADDR_W(AW), .WR_STYLE(WR_SETCLR), .DIR_STYLE(DIR_OUT_HI),
        .REVERSED(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rd0), .pin_in(pins), .pin_out(out0), .pin_oe(oe0));
    // u1: plain, input-high direction, reversed order
    mmio_gpio_ctrl #(.W(W), .ADDR_W(AW), .WR_STYLE(WR_PLAIN), .DIR_STYLE(DIR_IN_HI),
        .REVERSED(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rd1), .pin_in(pins), .pin_out(out1), .pin_oe(oe1));
    // u2: set-only readable, no direction register
    mmio_gpio_ctrl #(.W(W), .ADDR_W(AW), .WR_STYLE(WR_SETONLY), .DIR_STYLE(DIR_NONE),
        .SET_READABLE(1'b1)) u2 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rd2), .pin_in(pins), .pin_out(out2), .pin_oe(oe2));
    // u3: set-only unreadable, no direction register
    mmio_gpio_ctrl #(.W(W), .ADDR_W(AW), .WR_STYLE(WR_SETONLY), .DIR_STYLE(DIR_NONE),
        .SET_READABLE(1'b0)) u3 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rd3), .pin_in(pins), .pin_out(out3), .pin_oe(oe3));

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic [2:0] a;
        logic [7:0] d;
        logic [7:0] e0;
        logic [7:0] e1;
        logic [7:0] e2;
    } vec_t;

    // offset, data, expected pin_out of u0, u1, u2/u3
    localparam vec_t TBL [9] = '{
        '{3'd1, 8'h0F, 8'h0F, 8'h00, 8'h0F},
        '{3'd1, 8'hA0, 8'hAF, 8'h00, 8'hA0},
        '{3'd2, 8'h05, 8'hAA, 8'h00, 8'hA0},
        '{3'd2, 8'h00, 8'hAA, 8'h00, 8'hA0},
        '{3'd0, 8'hFF, 8'hAA, 8'hFF, 8'hA0},
        '{3'd5, 8'hFF, 8'hAA, 8'hFF, 8'hA0},
        '{3'd1, 8'h00, 8'hAA, 8'hFF, 8'h00},
        '{3'd2, 8'hFF, 8'h00, 8'hFF, 8'h00},
        '{3'd1, 8'h81, 8'h81, 8'hFF, 8'h81}
    };

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0;
        #0.5;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        addr = 3'd3;
        #0.5;
        chk("R1 u0 out in reset", out0, 8'h00);
        chk("R1 u0 oe in reset", oe0, 8'h00);
        chk("R1 u1 oe in reset", oe1, 8'h00);
        chk("R1 u0 dir read", rd0, 8'h00);
        chk("R1 u1 dir read ones", rd1, 8'hFF);
        chk("R9 u2 oe all driven", oe2, 8'hFF);
        @(negedge clk);
        rst_n = 1'b1;

        // table: R3 R4 R5 R6 R10 R11
        for (int i = 0; i < 9; i++) begin
            wr(TBL[i].a, TBL[i].d);
            chk("R4 R5 u0 set/clear latch", out0, TBL[i].e0);
            chk("R3 R10 u1 plain latch", out1, TBL[i].e1);
            chk("R6 u2 set-only latch", out2, TBL[i].e2);
            chk("R6 u3 set-only latch", out3, TBL[i].e2);
        end

        // R6 readback and R11 absent registers
        addr = 3'd1;
        #0.5;
        chk("R6 u2 set readable", rd2, 8'h81);
        chk("R6 u3 set unreadable", rd3, 8'h00);
        chk("R11 u0 set offset reads zero", rd0, 8'h00);
        chk("R11 u1 set offset reads zero", rd1, 8'h00);
        addr = 3'd2;
        #0.5;
        chk("R11 u2 clear offset reads zero", rd2, 8'h00);
        addr = 3'd6;
        #0.5;
        chk("R11 u0 unmapped", rd0, 8'h00);
        chk("R11 u1 unmapped", rd1, 8'h00);
        chk("R11 u2 unmapped", rd2, 8'h00);

        // R12: write and read of the same register in one cycle
        @(negedge clk);
        addr = 3'd1; we = 1'b1; wdata = 8'h3C;
        #0.5;
        chk("R12 u2 same-cycle read old", rd2, 8'h81);
        chk("R12 u2 pins before edge", out2, 8'h81);
        @(negedge clk);
        we = 1'b0;
        #0.5;
        chk("R12 u2 read new", rd2, 8'h3C);
        chk("R12 u2 pins new", out2, 8'h3C);
        chk("R4 u0 set ORs", out0, 8'hBD);

        // R10: reversed plain write
        wr(3'd0, 8'h01);
        chk("R10 u1 bit0 drives pin7", out1, 8'h80);
        chk("R5 u0 data write ignored", out0, 8'hBD);

        // R7 R8 R9 direction
        wr(3'd3, 8'h0F);
        chk("R7 u0 oe", oe0, 8'h0F);
        chk("R8 R10 u1 oe", oe1, 8'h0F);
        chk("R9 u2 oe unchanged", oe2, 8'hFF);
        addr = 3'd3;
        #0.5;
        chk("R7 u0 dir readback", rd0, 8'h0F);
        chk("R8 u1 dir readback", rd1, 8'h0F);
        chk("R9 u2 dir reads zero", rd2, 8'h00);
        wr(3'd3, 8'hC0);
        chk("R7 u0 oe second", oe0, 8'hC0);
        chk("R8 R10 u1 oe second", oe1, 8'hFC);

        // R2 synchroniser latency
        @(negedge clk);
        addr = 3'd0;
        pins = 8'h36;
        @(negedge clk);
        #0.5;
        chk("R2 u0 after one edge", rd0, 8'h00);
        @(negedge clk);
        #0.5;
        chk("R2 u0 after two edges", rd0, 8'h36);
        chk("R2 R10 u1 reversed input", rd1, 8'h6C);

        // R1 reset mid-run
        rst_n = 1'b0;
        #0.5;
        chk("R1 u0 out after reset", out0, 8'h00);
        chk("R1 u1 out after reset", out1, 8'h00);
        chk("R1 u0 oe after reset", oe0, 8'h00);
        chk("R1 u1 oe after reset", oe1, 8'h00);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1..all actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule